// File: doc/BRIEF.md
# I/O Interrupt Redirection Controller

This block routes up to 24 interrupt input pins to interrupt delivery messages. Each pin owns a 64-bit redirection entry that gives the vector, delivery mode, destination mode, destination, polarity, trigger mode and a mask. Software reaches the ID register, a version register and every entry through a two-offset memory-mapped scheme. It first writes an index to the index offset. It then reads or writes the selected 32-bit word through the data window offset. Each entry is split into a low word and a high word, and each word is written on its own.

Inputs are sampled into a pending register. A level-triggered entry's pending bit follows its input. An edge-triggered entry's pending bit is set by a rising input and is cleared when its message is accepted. A pending, unmasked entry is served after its input asserts, and again after any write to any redirection entry. The controller emits one message at a time on a valid/ready interface, lowest entry number first. Each message holds stable until it is accepted. Pin 0 is folded onto entry 2.

Top module: `irq_router`

## Requirements
- R1: After reset the index register reads 0, the ID reads 0, every entry low word reads 0x00010000 (only the mask bit 16 set), every high word reads 0, and msg_valid is low.
- R2: Offset 0x00 reads and writes the index register in bits 7:0, and offset 0x10 is the data window. All other offsets read 0, and writes to them change nothing.
- R3: Window index 0x00 holds the ID in bits 31:24, and only those bits are stored. Index 0x01 reads 0x00170011, which is version 0x11 with 23 in bits 23:16. Index 0x02 reads 0. Writes to indices 0x01 and 0x02 are ignored. Indices 0x03 to 0x0F and indices 0x40 and above read 0.
- R4: Entry n is reached at index 0x10+2n for bits 31:0 and at index 0x11+2n for bits 63:32. Writing one word leaves the other word unchanged.
- R5: The entry fields are as follows. Vector is bits 7:0. Delivery mode is bits 10:8. Destination mode is bit 11. Polarity is bit 13. Trigger mode is bit 15, where 1 means level. Mask is bit 16. Destination is bits 63:56. Each message carries these fields exactly as the entry holds them.
- R6: A level-triggered entry's pending bit follows its input. The entry sends one message when its input rises and does not send again while the input stays high.
- R7: An edge-triggered entry becomes pending on a rising input. Its pending bit clears when its message is accepted, so an input held high gives exactly one message.
- R8: A masked entry sends nothing, but it keeps its pending bit. A later write that clears the mask sends the message.
- R9: Any write to any redirection entry word causes every pending, unmasked entry to be served again. This includes level entries whose input is still high.
- R10: Input pin 0 drives entry 2, combined by OR with pin 2. Entry 0 has no input.
- R11: Messages go out one at a time, lowest entry number first. A message stays valid and unchanged until msg_ready is seen high.
- R12: When the controller is idle, an input that rises before clock edge k gives msg_valid high after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_in | input | 24 | Interrupt input pins |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Delivery message accepted |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_dest_logical | output | 1 | Message destination mode |
| msg_polarity | output | 1 | Message polarity |
| msg_level | output | 1 | Message trigger mode, 1 for level |
| msg_dest | output | 8 | Message destination |

## Verification
The bench builds the controller with its default parameters: 24 pins, 8-bit offsets, version 0x11 and pin 0 folded onto entry 2. With these values the whole window range is in reach, from index 0x10 through 0x3F. So is the first unmapped index 0x40 just beyond it, and the merge of pin 0 into entry 2 next to a silent entry 0. Random word writes across the full index space are checked against a shadow copy. Directed pin sequences then cover edge and level pending behaviour, masking, re-service after writes, ordering of simultaneous requests, and the two-edge delivery latency.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;
   localparam int ENT_W = 64;

   // bus offsets and window indices
   localparam logic [7:0] OFS_INDEX  = 8'h00;
   localparam logic [7:0] OFS_WINDOW = 8'h10;
   localparam logic [7:0] IDX_ID     = 8'h00;
   localparam logic [7:0] IDX_VER    = 8'h01;
   localparam int         ENT_BASE   = 16;

   // entry field positions
   localparam int F_VEC  = 0;
   localparam int F_MODE = 8;
   localparam int F_DLOG = 11;
   localparam int F_POL  = 13;
   localparam int F_LVL  = 15;
   localparam int F_MASK = 16;
   localparam int F_DEST = 56;

   localparam logic [ENT_W-1:0] ENT_RESET = ENT_W'(1) << F_MASK;

   typedef struct packed {
      logic [7:0] dest;
      logic       level;
      logic       polarity;
      logic       dest_logical;
      logic [2:0] mode;
      logic [7:0] vector;
   } irq_msg_t;

   function automatic irq_msg_t entry_to_msg(input logic [ENT_W-1:0] e);
      irq_msg_t m;
      m.vector       = e[F_VEC +: 8];
      m.mode         = e[F_MODE +: 3];
      m.dest_logical = e[F_DLOG];
      m.polarity     = e[F_POL];
      m.level        = e[F_LVL];
      m.dest         = e[F_DEST +: 8];
      return m;
   endfunction
endpackage

// File: rtl/irq_router_regfile.sv
`timescale 1ns/1ps
module irq_router_regfile
   import irq_router_pkg::*;
#(
   parameter int         NUM_PINS = 24,
   parameter int         ADDR_W   = 8,
   parameter logic [7:0] VERSION  = 8'h11
)(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             reg_wr,
   input  logic [ADDR_W-1:0]                reg_addr,
   input  logic [31:0]                      reg_wdata,
   output logic [31:0]                      reg_rdata,
   output logic [7:0]                       index_o,
   output logic [NUM_PINS-1:0][ENT_W-1:0]   entries_o,
   output logic                             entry_wr_o
);
   localparam int         LAST_IDX = ENT_BASE + 2*NUM_PINS - 1;
   localparam logic [7:0] MAX_ENT  = 8'(NUM_PINS-1);

   logic [7:0]  index_q, id_q, ent_off;
   logic [6:0]  ent_sel;
   logic        sel_index, sel_window, wr_window, idx_entry, hi_half;
   logic [31:0] win_rd;

   assign sel_index  = (reg_addr == ADDR_W'(OFS_INDEX));
   assign sel_window = (reg_addr == ADDR_W'(OFS_WINDOW));
   assign wr_window  = reg_wr && sel_window;
   assign ent_off    = index_q - 8'(ENT_BASE);
   assign ent_sel    = ent_off[7:1];
   assign hi_half    = index_q[0];
   assign idx_entry  = (int'(index_q) >= ENT_BASE) && (int'(index_q) <= LAST_IDX);
   assign entry_wr_o = wr_window && idx_entry;
   assign index_o    = index_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q <= '0;
         id_q    <= '0;
      end else begin
         if (reg_wr && sel_index)
            index_q <= reg_wdata[7:0];
         if (wr_window && index_q == IDX_ID)
            id_q <= reg_wdata[31:24];
      end
   end

   for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_ent
      logic [ENT_W-1:0] ent_q;
      logic             hit;
      assign hit = entry_wr_o && (ent_sel == 7'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q <= ENT_RESET;
         else if (hit) begin
            if (hi_half) ent_q[63:32] <= reg_wdata;
            else         ent_q[31:0]  <= reg_wdata;
         end
      end
      assign entries_o[gi] = ent_q;
   end

   always_comb begin
      win_rd = '0;
      if (idx_entry) begin
         for (int i = 0; i < NUM_PINS; i++)
            if (ent_sel == 7'(i))
               win_rd = hi_half ? entries_o[i][63:32] : entries_o[i][31:0];
      end else begin
         case (index_q)
            IDX_ID:  win_rd = {id_q, 24'h0};
            IDX_VER: win_rd = {8'h00, MAX_ENT, 8'h00, VERSION};
            default: win_rd = '0;
         endcase
      end
   end

   assign reg_rdata = sel_index  ? {24'h0, index_q} :
                      sel_window ? win_rd : 32'h0;
endmodule

// File: rtl/irq_router_pending.sv
`timescale 1ns/1ps
module irq_router_pending #(
   parameter int NUM_PINS     = 24,
   parameter bit REMAP_PIN0   = 1'b1,
   parameter int REMAP_TARGET = 2,
   parameter int PIN_W        = 5
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] irq_in,
   input  logic [NUM_PINS-1:0] level_mode,
   input  logic                rearm_all,
   input  logic                clr_valid,
   input  logic [PIN_W-1:0]    clr_idx,
   output logic [NUM_PINS-1:0] src_o,
   output logic [NUM_PINS-1:0] rise_o,
   output logic [NUM_PINS-1:0] pend_o,
   output logic [NUM_PINS-1:0] armed_o
);
   logic [NUM_PINS-1:0] src, src_q, rise, clr, pend_q, armed_q;

   // source selection per entry: folding of pin 0 is a build option
   for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_src
      if (REMAP_PIN0 && gi == 0) begin : g_drop
         assign src[gi] = 1'b0;
      end else if (REMAP_PIN0 && gi == REMAP_TARGET) begin : g_merge
         assign src[gi] = irq_in[gi] | irq_in[0];
      end else begin : g_direct
         assign src[gi] = irq_in[gi];
      end
   end

   assign rise = src & ~src_q;
   assign clr  = clr_valid ? (NUM_PINS'(1) << clr_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q   <= '0;
         pend_q  <= '0;
         armed_q <= '0;
      end else begin
         src_q   <= src;
         // level entries mirror the input; edge entries latch a rise
         pend_q  <= (level_mode & src) | (~level_mode & ((pend_q & ~clr) | rise));
         armed_q <= rearm_all ? '1 : ((armed_q & ~clr) | rise);
      end
   end

   assign src_o   = src;
   assign rise_o  = rise;
   assign pend_o  = pend_q;
   assign armed_o = armed_q;
endmodule

// File: rtl/irq_router_sender.sv
`timescale 1ns/1ps
module irq_router_sender
   import irq_router_pkg::*;
#(
   parameter int NUM_PINS = 24,
   parameter int PIN_W    = 5
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_PINS-1:0]            eligible,
   input  logic [NUM_PINS-1:0][ENT_W-1:0] entries,
   input  logic                           msg_ready,
   output logic                           msg_valid,
   output irq_msg_t                       msg,
   output logic                           fire_o,
   output logic [PIN_W-1:0]               cur_o,
   output logic                           load_o,
   output logic [PIN_W-1:0]               pick_o
);
   logic                valid_q, found, fire, load;
   irq_msg_t            msg_q;
   logic [PIN_W-1:0]    cur_q, pick;
   logic [NUM_PINS-1:0] busy, cand;
   logic [ENT_W-1:0]    pick_ent;

   assign fire = valid_q & msg_ready;
   // the entry leaving this cycle must not be chosen again at the same edge
   assign busy = fire ? (NUM_PINS'(1) << cur_q) : '0;
   assign cand = eligible & ~busy;

   always_comb begin
      found    = 1'b0;
      pick     = '0;
      pick_ent = '0;
      for (int i = NUM_PINS-1; i >= 0; i--) begin
         if (cand[i]) begin
            found    = 1'b1;
            pick     = PIN_W'(i);
            pick_ent = entries[i];
         end
      end
   end

   assign load = found && (!valid_q || fire);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         cur_q   <= '0;
         msg_q   <= '0;
      end else if (load) begin
         valid_q <= 1'b1;
         cur_q   <= pick;
         msg_q   <= entry_to_msg(pick_ent);
      end else if (fire) begin
         valid_q <= 1'b0;
      end
   end

   assign msg_valid = valid_q;
   assign msg       = msg_q;
   assign fire_o    = fire;
   assign cur_o     = cur_q;
   assign load_o    = load;
   assign pick_o    = pick;
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
   import irq_router_pkg::*;
#(
   parameter int         NUM_PINS     = 24,
   parameter int         ADDR_W       = 8,
   parameter logic [7:0] VERSION      = 8'h11,
   parameter bit         REMAP_PIN0   = 1'b1,
   parameter int         REMAP_TARGET = 2
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic [NUM_PINS-1:0] irq_in,
   output logic                msg_valid,
   input  logic                msg_ready,
   output logic [7:0]          msg_vector,
   output logic [2:0]          msg_mode,
   output logic                msg_dest_logical,
   output logic                msg_polarity,
   output logic                msg_level,
   output logic [7:0]          msg_dest
);
   localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   if (NUM_PINS < 1 || NUM_PINS > 120) begin : g_bad_pins
      $error("irq_router: NUM_PINS must lie in 1..120 to fit the window");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("irq_router: ADDR_W must reach the window offset");
   end
   if (REMAP_PIN0 && (REMAP_TARGET < 1 || REMAP_TARGET >= NUM_PINS)) begin : g_bad_remap
      $error("irq_router: REMAP_TARGET outside the entry range");
   end

   logic [NUM_PINS-1:0][ENT_W-1:0] entries;
   logic                           entry_wr;
   logic [7:0]                     index_q;
   logic [NUM_PINS-1:0]            mask_vec, level_vec, src_vec, rise_vec;
   logic [NUM_PINS-1:0]            pend_vec, armed_vec, eligible;
   logic                           snd_fire, snd_load;
   logic [PIN_W-1:0]               snd_cur, snd_pick;
   irq_msg_t                       msg;

   irq_router_regfile #(
      .NUM_PINS (NUM_PINS),
      .ADDR_W   (ADDR_W),
      .VERSION  (VERSION)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .index_o    (index_q),
      .entries_o  (entries),
      .entry_wr_o (entry_wr)
   );

   for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_fields
      assign mask_vec[gi]  = entries[gi][F_MASK];
      assign level_vec[gi] = entries[gi][F_LVL];
   end

   irq_router_pending #(
      .NUM_PINS     (NUM_PINS),
      .REMAP_PIN0   (REMAP_PIN0),
      .REMAP_TARGET (REMAP_TARGET),
      .PIN_W        (PIN_W)
   ) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_in     (irq_in),
      .level_mode (level_vec),
      .rearm_all  (entry_wr),
      .clr_valid  (snd_fire),
      .clr_idx    (snd_cur),
      .src_o      (src_vec),
      .rise_o     (rise_vec),
      .pend_o     (pend_vec),
      .armed_o    (armed_vec)
   );

   assign eligible = pend_vec & armed_vec & ~mask_vec;

   irq_router_sender #(
      .NUM_PINS (NUM_PINS),
      .PIN_W    (PIN_W)
   ) u_send (
      .clk       (clk),
      .rst_n     (rst_n),
      .eligible  (eligible),
      .entries   (entries),
      .msg_ready (msg_ready),
      .msg_valid (msg_valid),
      .msg       (msg),
      .fire_o    (snd_fire),
      .cur_o     (snd_cur),
      .load_o    (snd_load),
      .pick_o    (snd_pick)
   );

   assign msg_vector       = msg.vector;
   assign msg_mode         = msg.mode;
   assign msg_dest_logical = msg.dest_logical;
   assign msg_polarity     = msg.polarity;
   assign msg_level        = msg.level;
   assign msg_dest         = msg.dest;
endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk #(
   parameter int         NUM_PINS = 24,
   parameter int         PIN_W    = 5,
   parameter int         ADDR_W   = 8,
   parameter logic [7:0] VERSION  = 8'h11
)(
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [31:0]         reg_rdata,
   input logic [7:0]          index_q,
   input logic                msg_valid,
   input logic                msg_ready,
   input logic [21:0]         msg_bits,
   input logic                snd_load,
   input logic [PIN_W-1:0]    snd_pick,
   input logic                snd_fire,
   input logic [PIN_W-1:0]    snd_cur,
   input logic [NUM_PINS-1:0] mask_vec,
   input logic [NUM_PINS-1:0] level_vec,
   input logic [NUM_PINS-1:0] src_vec,
   input logic [NUM_PINS-1:0] rise_vec,
   input logic [NUM_PINS-1:0] pend_vec
);
   logic                seen_q, clr_chk_q;
   logic [PIN_W-1:0]    clr_idx_q;
   logic [NUM_PINS-1:0] src_q, lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q    <= 1'b0;
         clr_chk_q <= 1'b0;
         clr_idx_q <= '0;
         src_q     <= '0;
         lvl_q     <= '0;
      end else begin
         seen_q    <= 1'b1;
         clr_chk_q <= snd_fire && !level_vec[snd_cur] && !rise_vec[snd_cur];
         clr_idx_q <= snd_cur;
         src_q     <= src_vec;
         lvl_q     <= level_vec;
      end
   end

   assert_msg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_bits));

   assert_only_live_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      snd_load |-> !mask_vec[snd_pick] && pend_vec[snd_pick]);

   assert_edge_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_chk_q |-> !pend_vec[clr_idx_q]);

   assert_level_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |-> ((pend_vec ^ src_q) & lvl_q) == '0);

   assert_version_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(8'h10)) && (index_q == 8'h01)
         |-> reg_rdata == {8'h00, 8'(NUM_PINS-1), 8'h00, VERSION});
endmodule

bind irq_router irq_router_chk #(
   .NUM_PINS (NUM_PINS),
   .PIN_W    (PIN_W),
   .ADDR_W   (ADDR_W),
   .VERSION  (VERSION)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .index_q   (index_q),
   .msg_valid (msg_valid),
   .msg_ready (msg_ready),
   .msg_bits  (msg),
   .snd_load  (snd_load),
   .snd_pick  (snd_pick),
   .snd_fire  (snd_fire),
   .snd_cur   (snd_cur),
   .mask_vec  (mask_vec),
   .level_vec (level_vec),
   .src_vec   (src_vec),
   .rise_vec  (rise_vec),
   .pend_vec  (pend_vec)
);

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;
   localparam int NP = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NP-1:0] irq_in = '0;
   logic        msg_valid, msg_ready = 1'b0;
   logic [7:0]  msg_vector, msg_dest;
   logic [2:0]  msg_mode;
   logic        msg_dest_logical, msg_polarity, msg_level;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [63:0] shadow [NP];
   logic [7:0]  sh_id;

   always #5 clk = ~clk;

   irq_router dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
      .msg_mode(msg_mode), .msg_dest_logical(msg_dest_logical),
      .msg_polarity(msg_polarity), .msg_level(msg_level), .msg_dest(msg_dest)
   );

   function automatic logic [31:0] exp_window(input logic [7:0] idx);
      if (idx == 8'h00) return {sh_id, 24'h0};
      if (idx == 8'h01) return 32'h0017_0011;
      if (idx >= 8'h10 && idx <= 8'h3F)
         return idx[0] ? shadow[(idx-8'h10)>>1][63:32] : shadow[(idx-8'h10)>>1][31:0];
      return 32'h0;
   endfunction

   function automatic logic [21:0] exp_msg(input logic [63:0] e);
      return {e[63:56], e[15], e[13], e[11], e[10:8], e[7:0]};
   endfunction

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
      bus_wr(8'h00, {24'h0, idx});
      bus_wr(8'h10, d);
      if (idx == 8'h00) sh_id = d[31:24];
      if (idx >= 8'h10 && idx <= 8'h3F) begin
         if (idx[0]) shadow[(idx-8'h10)>>1][63:32] = d;
         else        shadow[(idx-8'h10)>>1][31:0]  = d;
      end
   endtask

   task automatic win_chk(input string req, input logic [7:0] idx);
      logic [31:0] d;
      bus_wr(8'h00, {24'h0, idx});
      bus_rd(8'h10, d);
      check(req, $sformatf("window idx %h", idx), {32'h0, d}, {32'h0, exp_window(idx)});
   endtask

   task automatic set_entry(input int n, input logic [63:0] e);
      win_wr(8'(8'h11 + 2*n), e[63:32]);
      win_wr(8'(8'h10 + 2*n), e[31:0]);
   endtask

   task automatic take_msg(input string req, input logic [63:0] e);
      int w = 0;
      while (!msg_valid && w < 40) begin @(negedge clk); w++; end
      check(req, "msg_valid", {63'h0, msg_valid}, 64'h1);
      check(req, "msg fields",
            {42'h0, msg_dest, msg_level, msg_polarity, msg_dest_logical, msg_mode, msg_vector},
            {42'h0, exp_msg(e)});
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
   endtask

   task automatic no_msg(input string req, input int n);
      logic seen = 1'b0;
      repeat (n) begin @(negedge clk); if (msg_valid) seen = 1'b1; end
      check(req, "no message", {63'h0, seen}, 64'h0);
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d, d2;
      logic [63:0] e4, e6, e7, e0, e2, e9, e12, e20, e15, held;
      logic [21:0] snap;
      logic        bad;
      void'($urandom(32'd1234));
      for (int i = 0; i < NP; i++) shadow[i] = 64'h0000_0000_0001_0000;
      sh_id = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      check("R1", "msg_valid after reset", {63'h0, msg_valid}, 64'h0);
      bus_rd(8'h00, d);
      check("R1", "index after reset", {32'h0, d}, 64'h0);
      win_chk("R1", 8'h00);
      win_chk("R1", 8'h10);
      win_chk("R1", 8'h11);
      win_chk("R1", 8'h3E);
      win_chk("R1", 8'h3F);

      // R2 offsets
      bus_rd(8'h04, d);
      check("R2", "offset 04", {32'h0, d}, 64'h0);
      bus_wr(8'h00, 32'h0000_0013);
      bus_wr(8'h20, 32'hFFFF_FFFF);
      bus_rd(8'h00, d);
      check("R2", "index after stray write", {32'h0, d}, 64'h13);
      bus_rd(8'h14, d);
      check("R2", "offset 14", {32'h0, d}, 64'h0);

      // R3 ID, version, fixed-zero word, unmapped indices
      win_chk("R3", 8'h01);
      win_wr(8'h01, 32'hFFFF_FFFF);
      win_wr(8'h02, 32'hFFFF_FFFF);
      win_chk("R3", 8'h01);
      win_chk("R3", 8'h02);
      win_wr(8'h00, 32'hABCD_EF12);
      win_chk("R3", 8'h00);
      win_chk("R3", 8'h05);
      win_chk("R3", 8'h40);

      // R4 split words
      win_wr(8'h1A, 32'h0001_00AA);
      win_wr(8'h1B, 32'h1234_5678);
      win_chk("R4", 8'h1A);
      win_wr(8'h1A, 32'h0001_0055);
      win_chk("R4", 8'h1B);
      win_chk("R4", 8'h1A);

      // R2 R3 R4 random window traffic, pins idle
      bad = 1'b0;
      for (int it = 0; it < 150; it++) begin
         logic [7:0] idx;
         idx = 8'($urandom_range(0, 8'h4F));
         win_wr(idx, $urandom);
         idx = 8'($urandom_range(0, 8'h4F));
         win_chk("R4", idx);
         if (msg_valid) bad = 1'b1;
      end
      check("R8", "no message with idle pins", {63'h0, bad}, 64'h0);

      // R7 R12 R11 edge entry 4
      e4 = 64'h3C00_0000_0000_0041;
      set_entry(4, e4);
      @(negedge clk); irq_in[4] = 1'b1;
      @(negedge clk);
      check("R12", "valid one edge after rise", {63'h0, msg_valid}, 64'h0);
      @(negedge clk);
      check("R12", "valid two edges after rise", {63'h0, msg_valid}, 64'h1);
      snap = {msg_dest, msg_level, msg_polarity, msg_dest_logical, msg_mode, msg_vector};
      repeat (3) @(negedge clk);
      check("R11", "held valid", {63'h0, msg_valid}, 64'h1);
      check("R11", "held fields",
            {42'h0, msg_dest, msg_level, msg_polarity, msg_dest_logical, msg_mode, msg_vector},
            {42'h0, snap});
      take_msg("R7", e4);
      no_msg("R7", 6);
      @(negedge clk); irq_in[4] = 1'b0;

      // R6 R9 level entry 6
      e6 = 64'h5A00_0000_0000_A866;
      set_entry(6, e6);
      @(negedge clk); irq_in[6] = 1'b1;
      take_msg("R6", e6);
      no_msg("R6", 6);
      win_wr(8'h1D, e6[63:32]);
      take_msg("R9", e6);
      no_msg("R9", 4);
      @(negedge clk); irq_in[6] = 1'b0;
      repeat (2) @(negedge clk);
      win_wr(8'h1D, e6[63:32]);
      no_msg("R6", 6);

      // R8 masked entry 7
      e7 = 64'h0000_0000_0001_0077;
      set_entry(7, e7);
      @(negedge clk); irq_in[7] = 1'b1;
      @(negedge clk); irq_in[7] = 1'b0;
      no_msg("R8", 8);
      e7[16] = 1'b0;
      win_wr(8'h1E, e7[31:0]);
      take_msg("R8", e7);
      no_msg("R8", 4);

      // R10 pin 0 folded onto entry 2
      e0 = 64'h0100_0000_0000_0020;
      e2 = 64'h0200_0000_0000_0022;
      set_entry(0, e0);
      set_entry(2, e2);
      @(negedge clk); irq_in[0] = 1'b1;
      @(negedge clk); irq_in[0] = 1'b0;
      take_msg("R10", e2);
      no_msg("R10", 6);

      // R11 ordering of simultaneous requests
      e9  = 64'h0900_0000_0000_0090;
      e12 = 64'h0C00_0000_0000_00C0;
      e20 = 64'h1400_0000_0000_00D0;
      set_entry(20, e20);
      set_entry(9, e9);
      set_entry(12, e12);
      @(negedge clk); irq_in[20] = 1'b1; irq_in[12] = 1'b1; irq_in[9] = 1'b1;
      take_msg("R11", e9);
      take_msg("R11", e12);
      take_msg("R11", e20);
      @(negedge clk); irq_in[20] = 1'b0; irq_in[12] = 1'b0; irq_in[9] = 1'b0;
      no_msg("R11", 4);

      // R5 all message fields
      e15 = 64'hE700_0000_0000_2DF3;
      set_entry(15, e15);
      @(negedge clk); irq_in[15] = 1'b1;
      @(negedge clk); irq_in[15] = 1'b0;
      take_msg("R5", e15);
      held = e15;
      win_chk("R5", 8'h2E);
      win_chk("R5", 8'h2F);
      bus_rd(8'h00, d2);
      check("R5", "index after reads", {32'h0, d2}, 64'h2F);
      if (held != e15) $display("unreachable");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule